// File: doc/BRIEF.md
# Bit-logic scan controller

This block is a small programmable-controller core for discrete I/O. It keeps a short stored program of bit-logic instructions and runs it over and over while run mode is enabled. Each pass, called a scan, has four phases in a fixed order. First it takes a snapshot of the synchronised input pins. Then it executes the program. Then it waits through a housekeeping interval of fixed length. Finally it commits the output image to the output pins and pulses a scan-complete flag.

Each instruction works on a single-bit result register. A load starts a chain. AND and OR instructions combine further contacts into the result. A coil instruction writes the result into one output-image bit. A contact may address either the input image or the output image. A coil therefore feeds the contacts that follow it in the same scan, and it also feeds all later scans. This lets a rung latch itself on (seal-in), as in a start/stop motor circuit. The program is loaded through a simple write port while the engine is idle.

Top module: `plc_scan_core`

## Requirements
- R1: After reset, `dout` is 0 and `scan_done` is 0. Every program location holds END, so a freshly reset engine executes an empty program.
- R2: An instruction is 9 bits wide:
  - bits [8:6] hold the opcode: LD=0, AND=1, OR=2, COIL=3, END=4. The codes 5 to 7 behave as END.
  - bit [5] is the invert flag.
  - bit [4] selects the operand space: 0 for the input image, 1 for the output image.
  - bits [3:0] hold the bit index.
- R3: A contact value is the addressed image bit XOR the invert flag. With the flag clear, the contact is normally open and conducts on 1. With the flag set, it is normally closed and conducts on 0. LD puts the contact value into the result register. AND and OR combine it with the current result.
- R4: COIL writes the result register into the indexed output-image bit. Any later contact on that bit, in the same scan or in a later scan, reads the new value. This is what makes seal-in work.
- R5: `dout` changes only at the end-of-scan commit, on the same clock edge that raises `scan_done`. The one exception is the return to 0 when the engine goes idle (R8). `scan_done` stays high for exactly one cycle.
- R6: While running, consecutive `scan_done` pulses are N + HK_CYCLES + 2 cycles apart. N is the number of instructions executed, counting the END.
- R7: `din` passes through a two-flop synchroniser. The synchronised value is captured into the input image once, at the start of each scan. A change on `din` after that capture has no effect on the current scan's outputs.
- R8: When `run_en` goes low, the scan in progress finishes and commits its outputs. After that, `dout` is 0 and `scan_done` stays low. The output image is also cleared, so a restart begins with every coil off.
- R9: A program write (`prog_we`) takes effect only while the engine is idle. A write made during a scan is discarded.
- R10: Networks execute in program order from location 0. A later coil on the same output bit overrides an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run mode enable |
| din | input | NBITS | Discrete input pins (asynchronous) |
| dout | output | NBITS | Discrete output pins |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | AW | Program write address |
| prog_data | input | IW | Instruction word to write |
| scan_done | output | 1 | One-cycle pulse at each output commit |

## Verification
A wrong result register or output-image bit shows at the ports only at the next commit, which is up to one full scan later. The bench therefore compares `dout` against values worked out arithmetically, right after each `scan_done`. A corrupted phase counter or program counter shows up as a change in the spacing between `scan_done` pulses, and the bench measures that spacing cycle by cycle. If the input image leaked mid-scan, or the engine failed to stop on time, `dout` would change at a commit where it should have held. The bench targets exactly those commits.

// File: rtl/plc_scan_core.sv
module plc_scan_core #(
  parameter int NBITS = 16,
  parameter int DEPTH = 16,
  parameter int HK_CYCLES = 4,
  localparam int IDXW = $clog2(NBITS),
  localparam int AW = $clog2(DEPTH),
  localparam int IW = IDXW + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [NBITS-1:0] din,
  output logic [NBITS-1:0] dout,
  input  logic             prog_we,
  input  logic [AW-1:0]    prog_addr,
  input  logic [IW-1:0]    prog_data,
  output logic             scan_done
);
  localparam int HKW = $clog2(HK_CYCLES + 1);
  localparam logic [2:0] OP_LD = 3'd0, OP_AND = 3'd1, OP_OR = 3'd2, OP_COIL = 3'd3, OP_END = 3'd4;
  localparam logic [2:0] S_IDLE = 3'd0, S_SAMPLE = 3'd1, S_EXEC = 3'd2, S_HOUSE = 3'd3, S_COMMIT = 3'd4;

  logic [2:0]       state;
  logic [NBITS-1:0] sync1, sync2, in_img, out_img;
  logic [IW-1:0]    prog_mem [DEPTH];
  logic [AW-1:0]    pc;
  logic             acc;
  logic [HKW-1:0]   hk_cnt;
  logic [DEPTH*IW-1:0] mem_flat;

  wire [IW-1:0]   instr = prog_mem[pc];
  wire [2:0]      op    = instr[IW-1 -: 3];
  wire            inv   = instr[IDXW+1];
  wire            space = instr[IDXW];
  wire [IDXW-1:0] idx   = instr[IDXW-1:0];
  wire            contact = (space ? out_img[idx] : in_img[idx]) ^ inv;
  wire            last_step = (op >= OP_END) || (pc == AW'(DEPTH - 1));

  always_comb
    for (int i = 0; i < DEPTH; i++) mem_flat[i*IW +: IW] = prog_mem[i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) prog_mem[i] <= {OP_END, {(IW-3){1'b0}}};
    end else if (prog_we && state == S_IDLE) begin
      prog_mem[prog_addr] <= prog_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      in_img    <= '0;
      out_img   <= '0;
      dout      <= '0;
      pc        <= '0;
      acc       <= 1'b0;
      hk_cnt    <= '0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      case (state)
        S_IDLE: begin
          dout    <= '0;
          out_img <= '0;
          if (run_en) state <= S_SAMPLE;
        end
        S_SAMPLE: begin
          in_img <= sync2;
          pc     <= '0;
          state  <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_LD:   acc <= contact;
            OP_AND:  acc <= acc & contact;
            OP_OR:   acc <= acc | contact;
            OP_COIL: out_img[idx] <= acc;
            default: ;
          endcase
          pc <= pc + 1'b1;
          if (last_step) begin
            hk_cnt <= '0;
            state  <= S_HOUSE;
          end
        end
        S_HOUSE: begin
          hk_cnt <= hk_cnt + 1'b1;
          if (hk_cnt == HKW'(HK_CYCLES - 1)) state <= S_COMMIT;
        end
        S_COMMIT: begin
          dout      <= out_img;
          scan_done <= 1'b1;
          state     <= run_en ? S_SAMPLE : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/plc_scan_core_chk.sv
module plc_scan_core_chk #(
  parameter int NBITS = 16,
  parameter int DEPTH = 16,
  parameter int IW = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          state,
  input logic                scan_done,
  input logic [NBITS-1:0]    dout,
  input logic [NBITS-1:0]    in_img,
  input logic                prog_we,
  input logic [DEPTH*IW-1:0] mem_flat
);
  localparam logic [2:0] S_IDLE = 3'd0, S_SAMPLE = 3'd1;

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  p_dout_commit_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> (scan_done || dout == '0));

  p_idle_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state) == S_IDLE) |-> (dout == '0 && !scan_done));

  p_image_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_img) |-> $past(state) == S_SAMPLE);

  p_prog_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && state != S_IDLE) |=> $stable(mem_flat));
endmodule

bind plc_scan_core plc_scan_core_chk #(.NBITS(NBITS), .DEPTH(DEPTH), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .state(state), .scan_done(scan_done), .dout(dout),
  .in_img(in_img), .prog_we(prog_we), .mem_flat(mem_flat));

// File: tb/plc_scan_core_tb_top.sv
module plc_scan_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, prog_we = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [3:0] prog_addr = '0;
  logic [8:0] prog_data = '0;
  logic scan_done;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  plc_scan_core dut_i (.clk(clk), .rst_n(rst_n), .run_en(run_en), .din(din), .dout(dout),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data), .scan_done(scan_done));

  function automatic logic [8:0] ins(input logic [2:0] op, input logic inv, input logic sp, input logic [3:0] ix);
    return {op, inv, sp, ix};
  endfunction

  function automatic logic [15:0] exp1(input logic [7:0] d);
    logic [15:0] e = '0;
    e[0] = d[0] & d[1];
    e[1] = d[2] | d[3];
    e[2] = ~d[4] & ~d[5];
    e[3] = d[6] | ~d[7];
    e[4] = e[0];
    e[6] = 1'b0;
    return e;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input int a, input logic [8:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 4'(a); prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!scan_done);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    check("R1 dout", dout, 16'h0);
    check("R1 scan_done", 16'(scan_done), 16'h0);
    rst_n = 1'b1;
    // R1: empty program runs; outputs stay 0, period 1+4+2
    run_en = 1'b1; din = 16'hFFFF;
    wait_done(); wait_done();
    check("R1 empty program", dout, 16'h0);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!scan_done);
    check("R6 empty period", 16'(gap), 16'd7);
    run_en = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);

    // program 1 (R2 encoding, R3 contacts, R10 order)
    load(0,  ins(0,0,0,0)); load(1,  ins(1,0,0,1)); load(2,  ins(3,0,0,0));
    load(3,  ins(0,0,0,2)); load(4,  ins(2,0,0,3)); load(5,  ins(3,0,0,1));
    load(6,  ins(0,1,0,4)); load(7,  ins(1,1,0,5)); load(8,  ins(3,0,0,2));
    load(9,  ins(0,0,0,6)); load(10, ins(2,1,0,7)); load(11, ins(3,0,0,3));
    load(12, ins(0,0,1,0)); load(13, ins(3,0,0,4)); load(14, ins(7,0,0,0));
    run_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      din = 16'(v);
      wait_done(); wait_done();
      check("R3 R4 sweep", dout, exp1(8'(v)));
    end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!scan_done);
    check("R6 program period", 16'(gap), 16'd21);

    // R7: change during execution is invisible to the current scan
    din = 16'h0; wait_done(); wait_done();
    check("R7 baseline", dout, 16'h000C);
    repeat (3) @(negedge clk);
    din = 16'h0003;
    repeat (5) @(negedge clk);
    check("R5 stable mid-scan", dout, 16'h000C);
    wait_done();
    check("R7 late change hidden", dout, 16'h000C);
    wait_done();
    check("R7 seen next scan", dout, 16'h001D);

    // R9: write during run is discarded
    load(2, ins(3,0,0,5));
    din = 16'h0000; wait_done(); wait_done();
    check("R9 write ignored", dout, 16'h000C);

    // R8: stop, then program 2 (motor with seal-in and lamps)
    run_en = 1'b0;
    wait_done();
    @(negedge clk);
    check("R8 dark after stop", dout, 16'h0);
    gap = 0;
    repeat (60) begin @(negedge clk); if (scan_done) gap++; end
    check("R8 no pulses idle", 16'(gap), 16'h0);
    load(0, ins(0,0,0,0)); load(1, ins(2,0,1,0)); load(2, ins(1,0,0,1));
    load(3, ins(1,0,0,2)); load(4, ins(3,0,0,0)); load(5, ins(0,0,1,0));
    load(6, ins(3,0,0,1)); load(7, ins(0,1,1,0)); load(8, ins(3,0,0,2));
    load(9, ins(4,0,0,0));
    for (int a = 10; a < 16; a++) load(a, ins(4,0,0,0));
    din = 16'h0006; run_en = 1'b1;
    wait_done(); wait_done();
    check("R4 motor off lamp", dout, 16'h0004);
    din = 16'h0007; wait_done(); wait_done();
    check("R4 start pressed", dout, 16'h0003);
    din = 16'h0006; wait_done(); wait_done();
    check("R4 seal-in holds", dout, 16'h0003);
    din = 16'h0004; wait_done(); wait_done();
    check("R4 stop pressed", dout, 16'h0004);
    din = 16'h0006; wait_done(); wait_done();
    check("R4 stays off", dout, 16'h0004);
    din = 16'h0007; wait_done(); wait_done();
    din = 16'h0003; wait_done(); wait_done();
    check("R4 overload trips", dout, 16'h0004);
    din = 16'h0007; wait_done(); wait_done();
    din = 16'h0006; wait_done(); wait_done();
    check("R4 running again", dout, 16'h0003);
    run_en = 1'b0;
    wait_done();
    @(negedge clk);
    check("R8 stop dark", dout, 16'h0);
    run_en = 1'b1;
    wait_done();
    check("R8 restart all off", dout, 16'h0004);

    // R10: later coil on the same bit wins
    run_en = 1'b0; wait_done(); repeat (2) @(negedge clk);
    load(9, ins(0,1,0,0)); load(10, ins(3,0,0,1)); load(11, ins(4,0,0,0));
    run_en = 1'b1; din = 16'h0007;
    wait_done(); wait_done();
    check("R10 last coil wins", dout, 16'h0001);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule